// File: doc/BRIEF.md
# Windowed Watchdog Timer

The block is a watchdog whose service interval is bounded on both sides. After the counter is zeroed, a closed interval follows, and then an open interval. Software must restart the watchdog with a clear strobe during the open interval.

A clear strobe that arrives during the closed interval raises a reset request. So does a counter that runs through the end of the open interval. The counter advances only on cycles where the count-enable input is high. This lets the count rate come from a slow tick that is generated elsewhere.

Software programs three control fields through a single write port: an enable bit and two 5-bit exponents. A write to that port zeroes the counter and raises no request. The closed interval lasts 2^(closed_exp+1) ticks. The open interval lasts 2^(open_exp+1) ticks. The full timeout is the sum of the two. The current count is always visible on a status output.

Top module: `win_watchdog`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it is released, `count_o` is 0 and `rst_req_o` is 0. The watchdog starts disabled.
- R2: While enabled, `count_o` increases by one after each clock edge where `tick_i` is 1 and no other event applies. It holds when `tick_i` is 0. While disabled, `count_o` stays at 0.
- R3: Let C = 2^(closed_exp+1). When enabled, a `kick_i` at a count below C makes `rst_req_o` 1 in the next cycle and zeroes `count_o`.
- R4: When enabled, a `kick_i` at a count of C or more, with no timeout in that cycle, zeroes `count_o` and leaves `rst_req_o` at 0.
- R5: Let T = C + 2^(open_exp+1). When enabled, a `tick_i` at count T-1 makes `rst_req_o` 1 in the next cycle and zeroes `count_o`.
- R6: A cycle with `cfg_we_i` high loads `cfg_en_i`, `cfg_closed_exp_i` and `cfg_open_exp_i`. It zeroes `count_o` with `rst_req_o` 0, whatever the count is. It overrides any kick or timeout in the same cycle.
- R7: While disabled, `kick_i` has no effect: `rst_req_o` stays 0 and `count_o` stays 0.
- R8: When a kick and a timeout fall in the same cycle, the timeout wins: `rst_req_o` is 1 in the next cycle.
- R9: `rst_req_o` is high for one cycle per event, with `count_o` already 0. The enable bit stays set, and counting resumes from 0 on the next ticks.
- R10: `count_o` is 2^EXP_W+2 bits wide. With both exponents at 31 it counts without wrapping, and the closed interval covers counts far above small values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Counter advance enable |
| cfg_we_i | input | 1 | Control write strobe |
| cfg_en_i | input | 1 | Enable value written by `cfg_we_i` |
| cfg_closed_exp_i | input | EXP_W | Closed-interval exponent |
| cfg_open_exp_i | input | EXP_W | Open-interval exponent |
| kick_i | input | 1 | Clear strobe |
| rst_req_o | output | 1 | One-cycle reset request |
| count_o | output | 2^EXP_W+2 | Current counter value |

## Verification
Two things can land on the same edge: the clear strobe and the timeout tick at count T-1. The bench drives `kick_i` and `tick_i` together at exactly that count and expects a reset request. A control write that lands on the same edge as a due timeout is also provoked, and there the bench expects a zero count with no request. A scoreboard model, written from the interval arithmetic, predicts the count and the request for every driven cycle. It compares each prediction one cycle after the edge it concerns.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;
  typedef enum logic [1:0] {
    EV_NONE,
    EV_KICK,
    EV_EARLY,
    EV_EXPIRE
  } wd_evt_e;
endpackage

// File: rtl/wwdt_cfg.sv
module wwdt_cfg #(
  parameter int unsigned EXP_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             en_i,
  input  logic [EXP_W-1:0] cexp_i,
  input  logic [EXP_W-1:0] oexp_i,
  output logic             en_o,
  output logic [EXP_W-1:0] cexp_o,
  output logic [EXP_W-1:0] oexp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      cexp_o <= '0;
      oexp_o <= '0;
    end else if (we_i) begin
      en_o   <= en_i;
      cexp_o <= cexp_i;
      oexp_o <= oexp_i;
    end
  end
endmodule

// File: rtl/wwdt_window.sv
module wwdt_window #(
  parameter int unsigned EXP_W = 5,
  parameter int unsigned CNT_W = 34
) (
  input  logic [EXP_W-1:0] cexp_i,
  input  logic [EXP_W-1:0] oexp_i,
  output logic [CNT_W-1:0] closed_len_o,
  output logic [CNT_W-1:0] total_len_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [EXP_W:0]   c_sh, o_sh;
  logic [CNT_W-1:0] open_len;

  always_comb begin
    c_sh         = {1'b0, cexp_i} + (EXP_W+1)'(1);
    o_sh         = {1'b0, oexp_i} + (EXP_W+1)'(1);
    closed_len_o = ONE << c_sh;
    open_len     = ONE << o_sh;
    total_len_o  = closed_len_o + open_len;
  end
endmodule

// File: rtl/wwdt_judge.sv
module wwdt_judge
  import wwdt_pkg::*;
#(
  parameter int unsigned CNT_W = 34
) (
  input  logic             en_i,
  input  logic             we_i,
  input  logic             tick_i,
  input  logic             kick_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] closed_len_i,
  input  logic [CNT_W-1:0] total_len_i,
  output wd_evt_e          evt_o
);
  logic at_end;

  always_comb begin
    at_end = (count_i == total_len_i - CNT_W'(1));
    evt_o  = EV_NONE;
    if (en_i && !we_i) begin
      // timeout outranks a clear in the same cycle
      if (tick_i && at_end)                   evt_o = EV_EXPIRE;
      else if (kick_i && count_i < closed_len_i) evt_o = EV_EARLY;
      else if (kick_i)                        evt_o = EV_KICK;
    end
  end
endmodule

// File: rtl/wwdt_counter.sv
module wwdt_counter
  import wwdt_pkg::*;
#(
  parameter int unsigned CNT_W = 34
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             we_i,
  input  logic             tick_i,
  input  wd_evt_e          evt_i,
  output logic [CNT_W-1:0] count_o,
  output logic             rst_req_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o   <= '0;
      rst_req_o <= 1'b0;
    end else begin
      rst_req_o <= 1'b0;
      if (we_i || !en_i) begin
        count_o <= '0;
      end else begin
        unique case (evt_i)
          EV_EXPIRE, EV_EARLY: begin
            count_o   <= '0;
            rst_req_o <= 1'b1;
          end
          EV_KICK: count_o <= '0;
          default: if (tick_i) count_o <= count_o + CNT_W'(1);
        endcase
      end
    end
  end
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import wwdt_pkg::*;
#(
  parameter int unsigned EXP_W = 5,
  localparam int unsigned CNT_W = (2 ** EXP_W) + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cfg_we_i,
  input  logic             cfg_en_i,
  input  logic [EXP_W-1:0] cfg_closed_exp_i,
  input  logic [EXP_W-1:0] cfg_open_exp_i,
  input  logic             kick_i,
  output logic             rst_req_o,
  output logic [CNT_W-1:0] count_o
);
  logic             cfg_en;
  logic [EXP_W-1:0] cfg_cexp, cfg_oexp;
  logic [CNT_W-1:0] closed_len, total_len;
  wd_evt_e          evt;

  wwdt_cfg #(.EXP_W(EXP_W)) u_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (cfg_we_i),
    .en_i  (cfg_en_i),
    .cexp_i(cfg_closed_exp_i),
    .oexp_i(cfg_open_exp_i),
    .en_o  (cfg_en),
    .cexp_o(cfg_cexp),
    .oexp_o(cfg_oexp)
  );

  wwdt_window #(.EXP_W(EXP_W), .CNT_W(CNT_W)) u_window (
    .cexp_i      (cfg_cexp),
    .oexp_i      (cfg_oexp),
    .closed_len_o(closed_len),
    .total_len_o (total_len)
  );

  wwdt_judge #(.CNT_W(CNT_W)) u_judge (
    .en_i        (cfg_en),
    .we_i        (cfg_we_i),
    .tick_i      (tick_i),
    .kick_i      (kick_i),
    .count_i     (count_o),
    .closed_len_i(closed_len),
    .total_len_i (total_len),
    .evt_o       (evt)
  );

  wwdt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (cfg_en),
    .we_i     (cfg_we_i),
    .tick_i   (tick_i),
    .evt_i    (evt),
    .count_o  (count_o),
    .rst_req_o(rst_req_o)
  );
endmodule

// File: rtl/win_watchdog_chk.sv
module win_watchdog_chk #(
  parameter int unsigned CNT_W = 34
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             cfg_we_i,
  input logic             kick_i,
  input logic             rst_req_o,
  input logic [CNT_W-1:0] count_o,
  input logic             cfg_en,
  input logic [CNT_W-1:0] closed_len,
  input logic [CNT_W-1:0] total_len
);
  a_r2_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_en && !tick_i && !kick_i && !cfg_we_i) |=> $stable(count_o));

  a_r2_zero_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en |-> count_o == '0);

  a_r3_early_kick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_en && kick_i && !cfg_we_i && count_o < closed_len) |=> (rst_req_o && count_o == '0));

  a_r4_open_kick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_en && kick_i && !cfg_we_i && count_o >= closed_len &&
     !(tick_i && count_o == total_len - CNT_W'(1))) |=> (!rst_req_o && count_o == '0));

  a_r5_expire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_en && tick_i && !cfg_we_i && count_o == total_len - CNT_W'(1)) |=> (rst_req_o && count_o == '0));

  a_r6_cfg_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (!rst_req_o && count_o == '0));

  a_r7_kick_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_en && !cfg_we_i && kick_i) |=> !rst_req_o);

  a_r9_req_count_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> count_o == '0);

  a_r10_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en |-> count_o < total_len);
endmodule

bind win_watchdog win_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .cfg_we_i  (cfg_we_i),
  .kick_i    (kick_i),
  .rst_req_o (rst_req_o),
  .count_o   (count_o),
  .cfg_en    (cfg_en),
  .closed_len(closed_len),
  .total_len (total_len)
);

// File: tb/win_watchdog_test.sv
`timescale 1ns/1ps
module win_watchdog_test;
  localparam int unsigned EXP_W = 5;
  localparam int unsigned CNT_W = (2 ** EXP_W) + 2;

  typedef struct {
    int     due;
    longint cnt;
    bit     req;
    string  tag;
  } item_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tick = 1'b0, we = 1'b0, en = 1'b0, kick = 1'b0;
  logic [EXP_W-1:0] cexp = '0, oexp = '0;
  logic             rst_req;
  logic [CNT_W-1:0] count;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;
  item_t q[$];

  bit     m_en = 1'b0;
  int     m_c = 0, m_o = 0;
  longint m_cnt = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  win_watchdog #(.EXP_W(EXP_W)) uut (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .tick_i          (tick),
    .cfg_we_i        (we),
    .cfg_en_i        (en),
    .cfg_closed_exp_i(cexp),
    .cfg_open_exp_i  (oexp),
    .kick_i          (kick),
    .rst_req_o       (rst_req),
    .count_o         (count)
  );

  task automatic chk(input longint act, input longint exp, input string tag, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // monitor: compare each prediction in the cycle it falls due
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      it = q.pop_front();
      chk(longint'(count), it.cnt, it.tag, "count");
      chk(longint'(rst_req), longint'(it.req), it.tag, "rst_req");
    end
  end

  // driver: one clock of stimulus plus the predicted result
  task automatic step(input bit w, input bit e, input int c, input int o,
                      input bit k, input bit t, input string tag);
    longint closed_l, total_l;
    bit r;
    item_t it;
    we = w; en = e; cexp = EXP_W'(c); oexp = EXP_W'(o); kick = k; tick = t;
    r = 1'b0;
    if (w) begin
      m_en = e; m_c = c; m_o = o; m_cnt = 0;
    end else if (m_en) begin
      closed_l = 64'd1 << (m_c + 1);
      total_l  = closed_l + (64'd1 << (m_o + 1));
      if (t && m_cnt == total_l - 1) begin
        m_cnt = 0; r = 1'b1;
      end else if (k) begin
        if (m_cnt < closed_l) r = 1'b1;
        m_cnt = 0;
      end else if (t) m_cnt++;
    end
    it.due = cyc + 1; it.cnt = m_cnt; it.req = r; it.tag = tag;
    q.push_back(it);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 1, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    chk(longint'(count), 0, "R1", "count in reset");
    @(negedge clk);
    rst_n = 1'b1;
    chk(longint'(count), 0, "R1", "count after reset");
    chk(longint'(rst_req), 0, "R1", "rst_req after reset");

    ticks(3, "R2");                          // disabled: stays zero
    step(0, 0, 0, 0, 1, 1, "R7");            // kick while disabled
    step(0, 0, 0, 0, 1, 0, "R7");

    step(1, 1, 1, 0, 0, 0, "R6");            // closed 4, total 6
    ticks(2, "R2");
    step(0, 0, 0, 0, 0, 0, "R2");            // hold without tick
    step(0, 0, 0, 0, 1, 0, "R3");            // kick at 2 < 4
    step(0, 0, 0, 0, 0, 0, "R9");
    ticks(4, "R9");                          // resumes from zero
    step(0, 0, 0, 0, 1, 0, "R4");            // kick at 4
    ticks(5, "R5");
    step(0, 0, 0, 0, 0, 1, "R5");            // tick at 5 -> expire
    step(0, 0, 0, 0, 0, 1, "R9");
    ticks(4, "R8");
    step(0, 0, 0, 0, 1, 1, "R8");            // kick and expire together
    step(0, 0, 0, 0, 0, 0, "R9");

    ticks(3, "R6");
    step(1, 1, 0, 1, 1, 0, "R6");            // write with kick: no request
    ticks(5, "R6");
    step(1, 1, 0, 1, 0, 1, "R6");            // write on timeout edge
    step(0, 0, 0, 0, 1, 0, "R3");            // kick at 0 < 2

    step(1, 1, 31, 31, 0, 0, "R10");
    ticks(40, "R10");
    step(0, 0, 0, 0, 1, 0, "R10");           // 40 lies deep in closed window

    step(1, 0, 2, 2, 0, 0, "R6");
    step(0, 0, 0, 0, 1, 1, "R7");
    ticks(2, "R2");

    @(negedge clk);
    finish_run();
  end
endmodule